// File: doc/BRIEF.md
# PRD Table Builder

This block turns a stream of scatter-gather segments into descriptor-table dwords for a bus-master disk DMA engine. Each segment arrives as a 32-bit bus address and a byte length over a valid/ready handshake, with a flag on the final segment of a request. The block cuts every segment into pieces that stay inside one 64 KB address window. Each piece is emitted as two dwords on an output valid/ready stream: first the base address, then a count word. The caller writes those dwords to table memory in the order they appear.

Two count encodings are selectable. In the standard encoding the byte count sits in the low half of the count word, a full 64 KB piece is broken into two 32 KB entries for controllers that read a zero count as zero, and bit 31 of the final count word marks the end of the table. In the alternate encoding the count word holds the number of dwords minus one in its upper half, and there is no end marker. The final count word of a table is held back until the request's last segment has been seen, so the end marker can be placed without any table storage.

When a table cannot be built, the block reports a fallback so the request can be served by programmed I/O instead. This happens when the table would exceed its entry limit, when the request produces no entries, or when a segment is misaligned. In every case the reported entry count is zero, and any segments that remain in the request are accepted and discarded.

Top module: `prd_table_gen`

## Requirements
- R1: A piece's length is the smaller of the bytes left in the segment and 0x10000 minus the low 16 bits of the current address. The next piece starts at the address just past the previous one.
- R2: Each entry is emitted as two dwords, address dword first. In the standard encoding, bits 15:0 of the count word hold the piece's byte count and bits 30:16 are zero.
- R3: In the standard encoding, a piece of exactly 0x10000 bytes is emitted as two entries: the first at its base with count 0x8000, the second at base+0x8000 with count 0x8000. In the alternate encoding the same piece stays one entry.
- R4: In the standard encoding, bit 31 of the table's final count word is 1 and bit 31 of every other count word is 0. `out_last` is high only with that final dword.
- R5: With `alt_fmt`=1, the count word equals ((bytes >> 2) - 1) << 16, and bit 31 is never set.
- R6: If a table would need more than MAX_ENTRIES entries, the build ends with `fallback`=1, `overflow_err`=1 and `entry_count`=0. Exactly MAX_ENTRIES entries is a success.
- R7: A request that yields no entries ends with `fallback`=1, `entry_count`=0, and both `overflow_err` and `align_err` at 0.
- R8: A segment is misaligned when address bit 0 or length bit 0 is 1 (standard encoding), or when address bits 1:0 or length bits 1:0 are nonzero (alternate encoding). A misaligned segment ends the build with `fallback`=1 and `align_err`=1.
- R9: After an error, every remaining segment up to and including the one flagged last is accepted and produces no output dwords. When the misaligned segment is the first one, the table emits no dwords at all.
- R10: `done` is high for exactly one cycle per request. While `done` is high, a successful build shows its entry total on `entry_count` with `fallback`=0. Outside `done`, all status outputs are zero.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R12: A segment of zero length produces no entries. When it is the last segment, the table is closed on the entry made before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid | input | 1 | A segment is offered |
| seg_ready | output | 1 | The block takes the offered segment |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | This segment ends the request |
| alt_fmt | input | 1 | 1 selects the dword-count encoding, 0 the standard byte-count encoding |
| out_valid | output | 1 | A table dword is offered |
| out_ready | input | 1 | The consumer takes the dword |
| out_data | output | 32 | Table dword (address or count word) |
| out_last | output | 1 | The offered dword is the final dword of the table |
| done | output | 1 | One-cycle end-of-request strobe |
| entry_count | output | clog2(MAX_ENTRIES+1) | Entries built; zero on failure |
| fallback | output | 1 | The build failed; use programmed I/O |
| overflow_err | output | 1 | Failure was due to the entry limit |
| align_err | output | 1 | Failure was due to a misaligned segment |

## Verification
The bench builds the block with MAX_ENTRIES set to 8 and LEN_W at 32. With that limit, a single segment of a few hundred kilobytes reaches the entry cap. Directed cases therefore hit both an exact fit of 8 entries and an overflow on the ninth, followed by drained segments. Random requests of one to four segments, with addresses biased toward 64 KB edges and lengths up to 144 KB, mix both encodings, misaligned inputs, zero-length segments and a stalling consumer.

// File: rtl/prd_pkg.sv
package prd_pkg;

    localparam int DW = 32;                       // dword width
    localparam int PW = 17;                       // piece length width (up to 0x10000)
    localparam logic [PW-1:0] WINDOW      = 17'h10000;
    localparam logic [PW-1:0] HALF_WINDOW = 17'h08000;

    typedef enum logic [2:0] {
        ST_TAKE     = 3'd0,
        ST_PLAN     = 3'd1,
        ST_SEND_CNT = 3'd2,
        ST_SEND_ADR = 3'd3,
        ST_SEND_END = 3'd4,
        ST_SKIP     = 3'd5,
        ST_REPORT   = 3'd6
    } build_st_e;

    typedef enum logic {
        FMT_STD = 1'b0,
        FMT_ALT = 1'b1
    } fmt_e;

    // Alignment rule: 2-byte granules for the byte-count format, 4-byte for the dword format.
    function automatic logic addr_unaligned(logic [1:0] addr_lo, logic [1:0] len_lo, fmt_e fmt);
        if (fmt == FMT_ALT)
            return (addr_lo != 2'b00) || (len_lo != 2'b00);
        return addr_lo[0] | len_lo[0];
    endfunction

    // Count dword for a piece of the given size.
    function automatic logic [DW-1:0] count_word(logic [PW-1:0] bytes, fmt_e fmt, logic final_e);
        logic [15:0] dwm1;
        dwm1 = 16'((bytes >> 2) - PW'(1));
        if (fmt == FMT_ALT)
            return {dwm1, 16'h0000};
        return {final_e, 15'h0000, bytes[15:0]};
    endfunction

endpackage

// File: rtl/prd_piece_calc.sv
module prd_piece_calc
    import prd_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic [15:0]       base_lo,
    input  logic [LEN_W-1:0]  remain,
    input  logic              alt,
    output logic [PW-1:0]     piece
);
    localparam int CW = (LEN_W > PW) ? LEN_W : PW;

    logic [PW-1:0] room;
    logic [CW-1:0] rem_x;
    logic [CW-1:0] room_x;
    logic [PW-1:0] fit;

    always_comb begin
        room   = WINDOW - {1'b0, base_lo};
        rem_x  = CW'(remain);
        room_x = CW'(room);
        fit    = (rem_x < room_x) ? PW'(remain) : room;
        // A full window is halved for the byte-count format: a 16-bit count of zero
        // is not trusted to mean 64 KB by every controller.
        if (!alt && fit == WINDOW)
            piece = HALF_WINDOW;
        else
            piece = fit;
    end

endmodule

// File: rtl/prd_word_sel.sv
module prd_word_sel
    import prd_pkg::*;
(
    input  build_st_e         st,
    input  logic [DW-1:0]     base,
    input  logic [PW-1:0]     held_bytes,
    input  fmt_e              fmt,
    output logic [DW-1:0]     word,
    output logic              last
);
    always_comb begin
        word = '0;
        last = 1'b0;
        case (st)
            ST_SEND_ADR: word = base;
            ST_SEND_CNT: word = count_word(held_bytes, fmt, 1'b0);
            ST_SEND_END: begin
                word = count_word(held_bytes, fmt, 1'b1);
                last = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/prd_table_gen.sv
module prd_table_gen
    import prd_pkg::*;
#(
    parameter int MAX_ENTRIES = 256,
    parameter int LEN_W       = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              seg_valid,
    output logic                              seg_ready,
    input  logic [31:0]                       seg_addr,
    input  logic [LEN_W-1:0]                  seg_len,
    input  logic                              seg_last,
    input  logic                              alt_fmt,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic [31:0]                       out_data,
    output logic                              out_last,
    output logic                              done,
    output logic [$clog2(MAX_ENTRIES+1)-1:0]  entry_count,
    output logic                              fallback,
    output logic                              overflow_err,
    output logic                              align_err
);
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ENTRIES);

    build_st_e          st;
    fmt_e               fmt;
    logic [DW-1:0]      cur_base;
    logic [LEN_W-1:0]   remain;
    logic               seg_end;
    logic [CNT_W-1:0]   entries;
    logic               held_ok;
    logic [PW-1:0]      held_bytes;
    logic [PW-1:0]      plan_bytes;
    logic [PW-1:0]      piece;
    logic               bad_align;
    logic               bad_ovf;
    logic               failed;

    assign fmt = fmt_e'(alt_fmt);

    prd_piece_calc #(.LEN_W(LEN_W)) u_piece (
        .base_lo (cur_base[15:0]),
        .remain  (remain),
        .alt     (alt_fmt),
        .piece   (piece)
    );

    prd_word_sel u_word (
        .st         (st),
        .base       (cur_base),
        .held_bytes (held_bytes),
        .fmt        (fmt),
        .word       (out_data),
        .last       (out_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_TAKE;
            cur_base   <= '0;
            remain     <= '0;
            seg_end    <= 1'b0;
            entries    <= '0;
            held_ok    <= 1'b0;
            held_bytes <= '0;
            plan_bytes <= '0;
            bad_align  <= 1'b0;
            bad_ovf    <= 1'b0;
        end else begin
            unique case (st)
                ST_TAKE: if (seg_valid) begin
                    cur_base <= seg_addr;
                    remain   <= seg_len;
                    seg_end  <= seg_last;
                    if (addr_unaligned(seg_addr[1:0], seg_len[1:0], fmt)) begin
                        bad_align <= 1'b1;
                        st        <= seg_last ? ST_REPORT : ST_SKIP;
                    end else begin
                        st <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (remain == '0) begin
                        if (!seg_end)
                            st <= ST_TAKE;
                        else if (held_ok)
                            st <= ST_SEND_END;
                        else
                            st <= ST_REPORT;        // empty table
                    end else if (entries == CAP) begin
                        bad_ovf <= 1'b1;
                        st      <= seg_end ? ST_REPORT : ST_SKIP;
                    end else begin
                        plan_bytes <= piece;
                        st         <= held_ok ? ST_SEND_CNT : ST_SEND_ADR;
                    end
                end
                ST_SEND_CNT: if (out_ready) st <= ST_SEND_ADR;
                ST_SEND_ADR: if (out_ready) begin
                    held_bytes <= plan_bytes;
                    held_ok    <= 1'b1;
                    entries    <= entries + CNT_W'(1);
                    cur_base   <= cur_base + DW'(plan_bytes);
                    remain     <= remain - LEN_W'(plan_bytes);
                    st         <= ST_PLAN;
                end
                ST_SEND_END: if (out_ready) st <= ST_REPORT;
                ST_SKIP: if (seg_valid && seg_last) st <= ST_REPORT;
                ST_REPORT: begin
                    st        <= ST_TAKE;
                    entries   <= '0;
                    held_ok   <= 1'b0;
                    bad_align <= 1'b0;
                    bad_ovf   <= 1'b0;
                end
                default: st <= ST_TAKE;
            endcase
        end
    end

    assign seg_ready    = (st == ST_TAKE) || (st == ST_SKIP);
    assign out_valid    = (st == ST_SEND_CNT) || (st == ST_SEND_ADR) || (st == ST_SEND_END);
    assign done         = (st == ST_REPORT);
    assign failed       = bad_align | bad_ovf | (entries == '0);
    assign fallback     = done & failed;
    assign overflow_err = done & bad_ovf;
    assign align_err    = done & bad_align;
    assign entry_count  = (done && !failed) ? entries : '0;

    // R1: a planned piece is nonempty and ends at or before the next 64 KB edge
    p_piece_in_window_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PLAN && remain != '0) |->
            (piece != '0 && (18'(cur_base[15:0]) + 18'(piece)) <= 18'h10000));

    // R3: the byte-count format never plans a full-window piece
    p_no_full_window_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PLAN && remain != '0 && !alt_fmt) |-> piece <= HALF_WINDOW || piece < WINDOW);

    // R4: the closing word carries the end marker in the byte-count format
    p_end_marker_r4: assert property (@(posedge clk) disable iff (rst)
        (out_last && !alt_fmt) |-> out_data[31]);

    // R5: the dword-count format never sets bit 31
    p_alt_no_marker_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && alt_fmt && st != ST_SEND_ADR) |-> !out_data[31]);

    // R6: the entry tally never passes the limit
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        entries <= CAP);

    // R6 / R7: a failed build never reports entries
    p_fail_zero_count_r7: assert property (@(posedge clk) disable iff (rst)
        (done && fallback) |-> entry_count == '0);

    // R9: nothing is emitted while input segments are taken
    p_quiet_when_taking_r9: assert property (@(posedge clk) disable iff (rst)
        seg_ready |-> !out_valid);

    // R10: completion strobe lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: a stalled dword stays put
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/test_prd_table_gen.sv
`timescale 1ns/1ps
module test_prd_table_gen;
    localparam int TB_MAX = 8;
    localparam int CW = $clog2(TB_MAX + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic seg_valid = 0, seg_last = 0, alt_fmt = 0, out_ready = 1;
    logic [31:0] seg_addr = 0, seg_len = 0;
    logic seg_ready, out_valid, out_last, done, fallback, overflow_err, align_err;
    logic [31:0] out_data;
    logic [CW-1:0] entry_count;

    prd_table_gen #(.MAX_ENTRIES(TB_MAX), .LEN_W(32)) i_prd_table_gen (
        .clk(clk), .rst(rst), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last), .alt_fmt(alt_fmt),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .done(done), .entry_count(entry_count), .fallback(fallback),
        .overflow_err(overflow_err), .align_err(align_err)
    );

    int n_checks = 0;
    int n_errs = 0;

    logic [31:0] seg_a [8];
    logic [31:0] seg_l [8];
    int  nseg;
    bit  ready_rand = 0;

    logic [31:0] exp_q [$];
    logic [31:0] got_q [$];
    bit          got_last_q [$];
    int  exp_cnt;
    bit  exp_fb, exp_ovf, exp_mis, exp_no_out;
    int  got_cnt;
    bit  got_fb, got_ovf, got_mis;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference table built from the requirements.
    function automatic void model();
        logic [31:0] a, l, b;
        int ent;
        exp_q.delete();
        exp_ovf = 0; exp_mis = 0; exp_no_out = 0; ent = 0;
        for (int i = 0; i < nseg; i++) begin
            a = seg_a[i]; l = seg_l[i];
            if (alt_fmt ? (a[1:0] != 0 || l[1:0] != 0) : (a[0] | l[0])) begin
                exp_mis = 1;
                exp_no_out = (i == 0);
                break;
            end
            while (l != 0) begin
                b = 32'h10000 - {16'h0, a[15:0]};
                if (b > l) b = l;
                if (!alt_fmt && b == 32'h10000) b = 32'h8000;
                if (ent == TB_MAX) begin exp_ovf = 1; break; end
                exp_q.push_back(a);
                exp_q.push_back(alt_fmt ? (((b >> 2) - 1) << 16) : b);
                ent++;
                a = a + b; l = l - b;
            end
            if (exp_ovf) break;
        end
        exp_fb  = exp_ovf | exp_mis | (ent == 0);
        exp_cnt = exp_fb ? 0 : ent;
        if (!exp_fb && !alt_fmt)
            exp_q[exp_q.size()-1] = exp_q[exp_q.size()-1] | 32'h8000_0000;
    endfunction

    task automatic drive_segs();
        @(negedge clk);
        for (int i = 0; i < nseg; i++) begin
            seg_valid = 1; seg_addr = seg_a[i]; seg_len = seg_l[i]; seg_last = (i == nseg - 1);
            while (1) begin
                if (seg_ready) begin @(negedge clk); break; end
                @(negedge clk);
            end
        end
        seg_valid = 0; seg_last = 0;
    endtask

    task automatic collect();
        bit stalled = 0;
        logic [31:0] prev = 0;
        while (1) begin
            @(negedge clk);
            if (stalled)
                check(out_valid && out_data == prev, "R11", "stalled dword held", out_data, prev);
            if (done) begin
                got_cnt = int'(entry_count); got_fb = fallback;
                got_ovf = overflow_err; got_mis = align_err;
                break;
            end
            out_ready = ready_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
            stalled = out_valid && !out_ready;
            prev = out_data;
            if (out_valid && out_ready) begin
                got_q.push_back(out_data);
                got_last_q.push_back(out_last);
            end
        end
        out_ready = 1;
    endtask

    task automatic run_table(input string req);
        model();
        got_q.delete(); got_last_q.delete();
        fork
            drive_segs();
            collect();
        join
        check(got_fb == exp_fb, req, "fallback", 32'(got_fb), 32'(exp_fb));
        check(got_ovf == exp_ovf, req, "overflow_err", 32'(got_ovf), 32'(exp_ovf));
        check(got_mis == exp_mis, req, "align_err", 32'(got_mis), 32'(exp_mis));
        check(got_cnt == exp_cnt, req, "entry_count", 32'(got_cnt), 32'(exp_cnt));
        if (exp_no_out)
            check(got_q.size() == 0, "R9", "dwords after early error", 32'(got_q.size()), 0);
        if (!exp_fb) begin
            check(got_q.size() == exp_q.size(), req, "dword total", 32'(got_q.size()), 32'(exp_q.size()));
            if (got_q.size() == exp_q.size())
                for (int k = 0; k < exp_q.size(); k++) begin
                    check(got_q[k] == exp_q[k], req, $sformatf("dword %0d", k), got_q[k], exp_q[k]);
                    check(got_last_q[k] == (k == exp_q.size() - 1), "R4", $sformatf("out_last %0d", k),
                          32'(got_last_q[k]), 32'(k == exp_q.size() - 1));
                end
        end
    endtask

    task automatic one(input logic [31:0] a, input logic [31:0] l, input bit alt, input string req);
        nseg = 1; seg_a[0] = a; seg_l[0] = l; alt_fmt = alt;
        run_table(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] a, l;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: idle state after reset
        check(seg_ready == 1 && out_valid == 0, "R10", "idle handshakes", {seg_ready, out_valid}, 2'b10);
        check(done == 0 && fallback == 0 && entry_count == 0, "R10", "idle status",
              {done, fallback, 30'(entry_count)}, 0);

        one(32'h0001_FFF0, 32'h30, 0, "R1");           // crosses one 64 KB edge
        one(32'h0004_0100, 32'h200, 0, "R2");
        one(32'h0003_0000, 32'h10000, 0, "R3");        // full window, halved
        one(32'h0003_0000, 32'h10000, 1, "R5");        // full window, one entry
        one(32'h0005_FFF8, 32'h18, 1, "R5");
        one(32'h0000_0000, 32'h40000, 0, "R6");        // exactly TB_MAX entries
        one(32'h0000_0000, 32'h48000, 0, "R6");        // one entry too many
        one(32'h0000_2000, 32'h0, 0, "R7");            // empty
        one(32'h0000_1001, 32'h10, 0, "R8");
        one(32'h0000_1002, 32'h10, 1, "R8");
        one(32'h0000_1000, 32'h16, 1, "R8");

        // R4: two segments, marker only on the closing count
        nseg = 2; alt_fmt = 0;
        seg_a[0] = 32'h0010_0000; seg_l[0] = 32'h80;
        seg_a[1] = 32'h0020_FF00; seg_l[1] = 32'h200;
        run_table("R4");

        // R9: misaligned first segment, two more to drain
        nseg = 3; alt_fmt = 0;
        seg_a[0] = 32'h0000_1001; seg_l[0] = 32'h10;
        seg_a[1] = 32'h0000_2000; seg_l[1] = 32'h10;
        seg_a[2] = 32'h0000_3000; seg_l[2] = 32'h10;
        run_table("R9");

        // R9: overflow then a drained segment
        nseg = 2; alt_fmt = 0;
        seg_a[0] = 32'h0; seg_l[0] = 32'h48000;
        seg_a[1] = 32'h0010_0000; seg_l[1] = 32'h10;
        run_table("R9");

        // R12: zero-length segment in the middle, and as the closing segment
        nseg = 3; alt_fmt = 0;
        seg_a[0] = 32'h0000_1000; seg_l[0] = 32'h100;
        seg_a[1] = 32'h0000_5000; seg_l[1] = 32'h0;
        seg_a[2] = 32'h0000_6000; seg_l[2] = 32'h40;
        run_table("R12");
        nseg = 2; alt_fmt = 1;
        seg_a[0] = 32'h0000_1000; seg_l[0] = 32'h100;
        seg_a[1] = 32'h0000_2000; seg_l[1] = 32'h0;
        run_table("R12");

        // Random requests with a stalling consumer
        ready_rand = 1;
        for (int t = 0; t < 60; t++) begin
            nseg = $urandom_range(1, 4);
            alt_fmt = $urandom_range(0, 1);
            for (int i = 0; i < nseg; i++) begin
                case ($urandom_range(0, 2))
                    0: a = $urandom;
                    1: a = {16'($urandom), 16'h0};
                    default: a = {16'($urandom), 16'h0} - 32'($urandom_range(1, 64) * 4);
                endcase
                a = alt_fmt ? (a & ~32'h3) : (a & ~32'h1);
                if ($urandom_range(0, 7) == 0) l = 0;
                else if ($urandom_range(0, 1) == 1) l = $urandom_range(1, 512);
                else l = $urandom_range(1, 32'h24000);
                l = alt_fmt ? (l & ~32'h3) : (l & ~32'h1);
                if ($urandom_range(0, 15) == 0) a[0] = 1'b1;
                seg_a[i] = a; seg_l[i] = l;
            end
            run_table("R2");
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule